// File: doc/BRIEF.md
# Parallel Bus Arbitration and Target Selection Sequencer

This block is the initiator-side sequencer that takes a shared eight-line parallel peripheral bus from idle to a selected target. After a start request carrying a target number, it waits for the bus to stay free for a set number of cycles. It then competes for ownership by pulling BSY and its own ID line. If it wins, it selects the target by pulling SEL together with the combined initiator and target ID lines. Any later phase of the connection belongs to other logic.

Every bus line is active low and open-collector. The block reports what it drives as per-line drive enables, and a drive always pulls the line low. Each unit ID is one data line, and a higher line number has higher priority. All delays are clock-cycle counts set by parameters: `FREE_DLY`, `ARB_DLY`, `SEL_HOLD` and `SEL_TMO`. Four single-cycle flags report the outcome: won, lost, selected and timeout.

The state machine has five states. `ST_IDLE` goes to `ST_WAIT_FREE` on a start request (transition *launch*). `ST_WAIT_FREE` goes to `ST_ARB` once the bus has been free for long enough (*free*). `ST_ARB` goes to `ST_SEL_DRIVE` on a win (*win*), or back to `ST_WAIT_FREE` on a loss (*lose*). `ST_SEL_DRIVE` goes to `ST_SEL_WAIT` when the hold time ends (*hand-off*). `ST_SEL_WAIT` goes to `ST_IDLE` either when the target answers (*answer*) or when the wait runs out (*expire*).

Top module: `bus_acq_ctrl`

## Requirements
- R1: After reset, no drive enable is active and all four flags are low.
- R2: The bus counts as free in a cycle where both `bsy_n_i` and `sel_n_i` are high. Arbitration starts only after `FREE_DLY` consecutive free cycles, and any busy cycle, on either line, restarts the count.
- R3: During arbitration, which lasts `ARB_DLY` cycles, the block drives BSY and only data line `MY_ID`. SEL is not driven.
- R4: At the end of arbitration, if no data line numbered above `MY_ID` is low, `won_o` pulses and SEL is driven together with BSY. Low lines numbered below `MY_ID` have no effect.
- R5: From the win until the end of selection, the data drive enables equal bit `MY_ID` OR bit `tgt_id_i`, using the target number latched at the start request.
- R6: If a data line numbered above `MY_ID` is low at the end of arbitration, `lost_o` pulses in the same cycle that BSY and the data lines are released. The block then waits for a fresh free period and retries without a new request.
- R7: After `SEL_HOLD` cycles, BSY is released while SEL stays driven. When `bsy_n_i` is sampled low with `io_n_i` high, `selected_o` pulses and every drive is released.
- R8: If no answer arrives within `SEL_TMO` cycles of the BSY release, `timeout_o` pulses and every drive is released. An answer sampled in the last cycle of the window still counts as a selection.
- R9: BSY asserted by a device while `io_n_i` is low does not complete the selection.
- R10: A start request made while a sequence is in progress is ignored, and the latched target is kept.
- R11: Each flag is a single-cycle pulse, and at most one flag is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to acquire the bus, taken in idle |
| tgt_id_i | input | ID_W | Target number for the request |
| bus_data_n_i | input | BUS_W | Sampled data lines, active low |
| bsy_n_i | input | 1 | Sampled BSY line, active low |
| sel_n_i | input | 1 | Sampled SEL line, active low |
| io_n_i | input | 1 | Sampled I/O line, active low |
| data_oe_o | output | BUS_W | Per-line pull-low enables for the data lines |
| bsy_oe_o | output | 1 | Pull-low enable for BSY |
| sel_oe_o | output | 1 | Pull-low enable for SEL |
| won_o | output | 1 | Pulse: arbitration won |
| lost_o | output | 1 | Pulse: arbitration lost |
| selected_o | output | 1 | Pulse: target answered |
| timeout_o | output | 1 | Pulse: target did not answer in time |

## Verification
A wrong state or a miscounted delay shows up on the drive enables in the very cycle it occurs. Examples are a BSY enable without a preceding free period, or SEL appearing without a win. A stale latched target appears as a wrong data-line pattern from the win onward. A counter that is off by one moves the won, selected or timeout pulse by exactly one cycle from the position computed from the parameters. Sampling every cycle of each sequence therefore exposes such faults within one cycle.

// File: rtl/bus_acq_pkg.sv
package bus_acq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_FREE,
        ST_ARB,
        ST_SEL_DRIVE,
        ST_SEL_WAIT
    } acq_state_t;

endpackage

// File: rtl/bus_acq_cnt.sv
module bus_acq_cnt #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    output logic [W-1:0] cnt_o
);
    localparam logic [W-1:0] TOP = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_o <= '0;
        else if (clr_i)
            cnt_o <= '0;
        else if (cnt_o != TOP)
            cnt_o <= cnt_o + 1'b1;
    end
endmodule

// File: rtl/bus_acq_prio.sv
module bus_acq_prio #(
    parameter int BUS_W = 8,
    parameter int MY_ID = 5
) (
    input  logic [BUS_W-1:0] bus_n_i,
    output logic             higher_o
);
    logic [BUS_W-1:0] above;

    for (genvar i = 0; i < BUS_W; i++) begin : g_line
        if (i > MY_ID) begin : g_hi
            assign above[i] = ~bus_n_i[i];
        end else begin : g_lo
            assign above[i] = 1'b0;
        end
    end

    assign higher_o = |above;
endmodule

// File: rtl/bus_acq_idbit.sv
module bus_acq_idbit #(
    parameter int BUS_W = 8,
    parameter int ID_W  = 3
) (
    input  logic [ID_W-1:0]  id_i,
    output logic [BUS_W-1:0] bit_o
);
    for (genvar i = 0; i < BUS_W; i++) begin : g_dec
        assign bit_o[i] = (id_i == ID_W'(i));
    end
endmodule

// File: rtl/bus_acq_ctrl.sv
module bus_acq_ctrl
    import bus_acq_pkg::*;
#(
    parameter int BUS_W    = 8,
    parameter int ID_W     = $clog2(BUS_W),
    parameter int MY_ID    = 5,
    parameter int FREE_DLY = 3,
    parameter int ARB_DLY  = 4,
    parameter int SEL_HOLD = 2,
    parameter int SEL_TMO  = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [ID_W-1:0]  tgt_id_i,
    input  logic [BUS_W-1:0] bus_data_n_i,
    input  logic             bsy_n_i,
    input  logic             sel_n_i,
    input  logic             io_n_i,
    output logic [BUS_W-1:0] data_oe_o,
    output logic             bsy_oe_o,
    output logic             sel_oe_o,
    output logic             won_o,
    output logic             lost_o,
    output logic             selected_o,
    output logic             timeout_o
);
    localparam int MAX_AB  = (FREE_DLY > ARB_DLY) ? FREE_DLY : ARB_DLY;
    localparam int MAX_CD  = (SEL_HOLD > SEL_TMO) ? SEL_HOLD : SEL_TMO;
    localparam int MAX_LIM = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
    localparam int CNT_W   = $clog2(MAX_LIM) + 1;

    localparam logic [CNT_W-1:0] FREE_LAST = CNT_W'(FREE_DLY - 1);
    localparam logic [CNT_W-1:0] ARB_LAST  = CNT_W'(ARB_DLY - 1);
    localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(SEL_HOLD - 1);
    localparam logic [CNT_W-1:0] TMO_LAST  = CNT_W'(SEL_TMO - 1);
    localparam logic [BUS_W-1:0] OWN_BIT   = BUS_W'(1) << MY_ID;

    acq_state_t       state_q, state_nxt;
    logic [ID_W-1:0]  tgt_q, tgt_nxt;
    logic [CNT_W-1:0] cnt;
    logic             cnt_clr;
    logic             bus_free;
    logic             higher_seen;
    logic             answer;
    logic [BUS_W-1:0] tgt_bit;
    logic             won_nxt, lost_nxt, sel_nxt, tmo_nxt;

    assign bus_free = bsy_n_i & sel_n_i;
    assign answer   = ~bsy_n_i & io_n_i;

    bus_acq_cnt #(.W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (cnt_clr),
        .cnt_o (cnt)
    );

    bus_acq_prio #(.BUS_W(BUS_W), .MY_ID(MY_ID)) u_prio (
        .bus_n_i  (bus_data_n_i),
        .higher_o (higher_seen)
    );

    bus_acq_idbit #(.BUS_W(BUS_W), .ID_W(ID_W)) u_idbit (
        .id_i  (tgt_q),
        .bit_o (tgt_bit)
    );

    // next-state and flag decisions
    always_comb begin
        state_nxt = state_q;
        tgt_nxt   = tgt_q;
        won_nxt   = 1'b0;
        lost_nxt  = 1'b0;
        sel_nxt   = 1'b0;
        tmo_nxt   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    tgt_nxt   = tgt_id_i;
                    state_nxt = ST_WAIT_FREE;
                end
            end
            ST_WAIT_FREE: begin
                if (bus_free && cnt == FREE_LAST)
                    state_nxt = ST_ARB;
            end
            ST_ARB: begin
                if (cnt == ARB_LAST) begin
                    if (higher_seen) begin
                        lost_nxt  = 1'b1;
                        state_nxt = ST_WAIT_FREE;
                    end else begin
                        won_nxt   = 1'b1;
                        state_nxt = ST_SEL_DRIVE;
                    end
                end
            end
            ST_SEL_DRIVE: begin
                if (cnt == HOLD_LAST)
                    state_nxt = ST_SEL_WAIT;
            end
            ST_SEL_WAIT: begin
                if (answer) begin
                    sel_nxt   = 1'b1;
                    state_nxt = ST_IDLE;
                end else if (cnt == TMO_LAST) begin
                    tmo_nxt   = 1'b1;
                    state_nxt = ST_IDLE;
                end
            end
            default: state_nxt = ST_IDLE;
        endcase
        cnt_clr = (state_nxt != state_q) ||
                  (state_q == ST_WAIT_FREE && !bus_free);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            tgt_q      <= '0;
            won_o      <= 1'b0;
            lost_o     <= 1'b0;
            selected_o <= 1'b0;
            timeout_o  <= 1'b0;
        end else begin
            state_q    <= state_nxt;
            tgt_q      <= tgt_nxt;
            won_o      <= won_nxt;
            lost_o     <= lost_nxt;
            selected_o <= sel_nxt;
            timeout_o  <= tmo_nxt;
        end
    end

    // bus drives decoded from the state
    always_comb begin
        data_oe_o = '0;
        bsy_oe_o  = 1'b0;
        sel_oe_o  = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_WAIT_FREE: ;
            ST_ARB: begin
                bsy_oe_o  = 1'b1;
                data_oe_o = OWN_BIT;
            end
            ST_SEL_DRIVE: begin
                bsy_oe_o  = 1'b1;
                sel_oe_o  = 1'b1;
                data_oe_o = OWN_BIT | tgt_bit;
            end
            ST_SEL_WAIT: begin
                sel_oe_o  = 1'b1;
                data_oe_o = OWN_BIT | tgt_bit;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/bus_acq_sva.sv
module bus_acq_sva #(
    parameter int BUS_W = 8,
    parameter int MY_ID = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bsy_n_i,
    input logic             sel_n_i,
    input logic [BUS_W-1:0] data_oe_o,
    input logic             bsy_oe_o,
    input logic             sel_oe_o,
    input logic             won_o,
    input logic             lost_o,
    input logic             selected_o,
    input logic             timeout_o
);
    localparam logic [BUS_W-1:0] OWN_BIT = BUS_W'(1) << MY_ID;

    p_free_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bsy_oe_o) |-> $past(bsy_n_i && sel_n_i));

    p_arb_own_line_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bsy_oe_o && !sel_oe_o) |-> (data_oe_o == OWN_BIT));

    p_sel_after_win_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sel_oe_o) |-> won_o);

    p_sel_lines_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sel_oe_o |-> (data_oe_o[MY_ID] && $countones(data_oe_o) <= 2));

    p_lost_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        lost_o |-> (!bsy_oe_o && !sel_oe_o && data_oe_o == '0));

    p_answer_in_wait_r7: assert property (@(posedge clk) disable iff (!rst_n)
        selected_o |-> ($past(sel_oe_o && !bsy_oe_o) && !sel_oe_o));

    p_timeout_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |-> (!bsy_oe_o && !sel_oe_o && data_oe_o == '0));

    p_one_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({won_o, lost_o, selected_o, timeout_o}));
endmodule

bind bus_acq_ctrl bus_acq_sva #(.BUS_W(BUS_W), .MY_ID(MY_ID)) u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .bsy_n_i    (bsy_n_i),
    .sel_n_i    (sel_n_i),
    .data_oe_o  (data_oe_o),
    .bsy_oe_o   (bsy_oe_o),
    .sel_oe_o   (sel_oe_o),
    .won_o      (won_o),
    .lost_o     (lost_o),
    .selected_o (selected_o),
    .timeout_o  (timeout_o)
);

// File: tb/bus_acq_ctrl_test.sv
module bus_acq_ctrl_test;
    localparam int BUS_W = 8;
    localparam int ID_W  = 3;
    localparam int MY_ID = 5;
    localparam int F = 3;
    localparam int A = 4;
    localparam int H = 2;
    localparam int T = 6;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [ID_W-1:0]  tgt_id = '0;
    logic [BUS_W-1:0] ext_data = '0;
    logic             ext_bsy = 1'b0, ext_sel = 1'b0, tgt_bsy = 1'b0, tgt_io = 1'b0;
    logic [BUS_W-1:0] data_oe;
    logic             bsy_oe, sel_oe, won, lost, selected, timeout;
    logic [BUS_W-1:0] bus_data_n;
    logic             bsy_n, sel_n, io_n;

    int checks = 0;
    int fails  = 0;

    assign bus_data_n = ~(data_oe | ext_data);
    assign bsy_n      = ~(bsy_oe | ext_bsy | tgt_bsy);
    assign sel_n      = ~(sel_oe | ext_sel);
    assign io_n       = ~tgt_io;

    always #2 clk = ~clk;

    bus_acq_ctrl #(
        .BUS_W(BUS_W), .ID_W(ID_W), .MY_ID(MY_ID),
        .FREE_DLY(F), .ARB_DLY(A), .SEL_HOLD(H), .SEL_TMO(T)
    ) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .tgt_id_i(tgt_id),
        .bus_data_n_i(bus_data_n), .bsy_n_i(bsy_n), .sel_n_i(sel_n), .io_n_i(io_n),
        .data_oe_o(data_oe), .bsy_oe_o(bsy_oe), .sel_oe_o(sel_oe),
        .won_o(won), .lost_o(lost), .selected_o(selected), .timeout_o(timeout)
    );

    task automatic chk(input bit good, input string req, input int act, input int exp);
        checks++;
        if (!good) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [12:0] outs();
        return {data_oe, bsy_oe, sel_oe, won, lost, selected, timeout};
    endfunction

    task automatic set_busy(input int edge_no, input int bf, input int bt, input bit on_sel);
        bit b;
        b = (bf > 0) && (edge_no >= bf) && (edge_no <= bt);
        if (on_sel) ext_sel = b; else ext_bsy = b;
    endtask

    // comp < 0: no competitor; resp < 0: target never answers
    task automatic run_case(input int tgt, input int comp, input int bf, input int bt,
                            input bit on_sel, input int resp, input bit resp_io,
                            input bit poke);
        int L, W, E;
        bit lose, ok;
        logic [BUS_W-1:0] own, sel_bits;
        logic [3:0] exp_f;
        lose     = (comp > MY_ID);
        L        = bt + F + A;
        W        = lose ? L + F + A : L;
        ok       = (resp >= 0) && (resp < T) && !resp_io;
        E        = ok ? W + H + resp + 1 : W + H + T;
        own      = BUS_W'(1) << MY_ID;
        sel_bits = own | (BUS_W'(1) << tgt);
        @(negedge clk);
        tgt_id   = ID_W'(tgt);
        start    = 1'b1;
        ext_data = (comp >= 0) ? (BUS_W'(1) << comp) : '0;
        set_busy(0, bf, bt, on_sel);
        @(negedge clk);
        start = 1'b0;
        set_busy(1, bf, bt, on_sel);
        for (int n = 1; n <= E + 1; n++) begin
            @(negedge clk);
            exp_f = {n == W, lose && n == L, ok && n == E, !ok && n == E};
            chk({won, lost, selected, timeout} == exp_f, "R11 flag timing",
                {won, lost, selected, timeout}, exp_f);
            if (n == W - 1)
                chk(bsy_oe && !sel_oe && data_oe == own, "R3 arbitration drive",
                    outs(), {own, 2'b10, 4'b0});
            if (n == W)
                chk(won && bsy_oe && sel_oe && data_oe == sel_bits,
                    "R4/R5 win and selection lines", outs(), {sel_bits, 2'b11, 4'b1000});
            if (lose && n == L)
                chk(lost && !bsy_oe && data_oe == '0, "R6 lost and release",
                    outs(), {8'h00, 2'b00, 4'b0100});
            if (n == W + H)
                chk(!bsy_oe && sel_oe && data_oe == sel_bits, "R7 BSY released, SEL held",
                    outs(), {sel_bits, 2'b01, 4'b0});
            if (n == E)
                chk(!bsy_oe && !sel_oe && data_oe == '0,
                    ok ? "R7 release after answer" : (resp_io ? "R9 io low ignored" : "R8 release on timeout"),
                    outs(), {8'h00, 2'b00, ok ? 4'b0010 : 4'b0001});
            if (poke && n == W + H) begin
                start  = 1'b1;
                tgt_id = ID_W'((tgt + 1) % BUS_W == MY_ID ? (tgt + 2) % BUS_W : (tgt + 1) % BUS_W);
            end
            if (poke && n == W + H + 1) start = 1'b0;
            if (poke && n == W + H + 2)
                chk(data_oe == sel_bits && sel_oe, "R10 start ignored mid-sequence",
                    data_oe, sel_bits);
            if (n == L) ext_data = '0;
            if (resp >= 0 && n == W + H + resp) begin
                tgt_bsy = 1'b1;
                tgt_io  = resp_io;
            end
            if (n == E) begin
                tgt_bsy = 1'b0;
                tgt_io  = 1'b0;
            end
            set_busy(n + 1, bf, bt, on_sel);
        end
        ext_bsy = 1'b0;
        ext_sel = 1'b0;
        repeat (2) @(negedge clk);
        chk(outs() == '0, "R11 quiet after sequence", outs(), 0);
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        chk(outs() == '0, "R1 reset state", outs(), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(outs() == '0, "R1 idle after reset", outs(), 0);
        // R5: every target number
        for (int t = 0; t < BUS_W; t++)
            if (t != MY_ID) run_case(t, -1, 0, 0, 1'b0, 1, 1'b0, 1'b0);
        // R4 / R6: every competitor line
        for (int c = 0; c < BUS_W; c++)
            if (c != MY_ID) run_case(0, c, 0, 0, 1'b0, 0, 1'b0, 1'b0);
        // R2: bus busy for a while, on BSY and on SEL
        for (int b = 1; b <= 4; b++) begin
            run_case(1, -1, 1, b, 1'b0, 2, 1'b0, 1'b0);
            run_case(2, -1, 1, b, 1'b1, 2, 1'b0, 1'b0);
        end
        // R2: busy glitch just before the free count completes
        run_case(3, -1, F, F, 1'b0, 0, 1'b0, 1'b0);
        run_case(3, -1, F, F + 1, 1'b1, 0, 1'b0, 1'b0);
        // R7 / R8: answer delay swept across the window edge
        for (int r = 0; r <= T; r++) run_case(4, -1, 0, 0, 1'b0, r, 1'b0, 1'b0);
        run_case(6, -1, 0, 0, 1'b0, -1, 1'b0, 1'b0);
        // R9: BSY with I/O asserted does not complete
        run_case(7, -1, 0, 0, 1'b0, 1, 1'b1, 1'b0);
        // R10: start pulse during selection wait
        run_case(1, -1, 0, 0, 1'b0, -1, 1'b0, 1'b1);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule